// File: doc/BRIEF.md
# Shared-Offset Line Format and Bank Select Register

This block holds two byte-wide registers that a host reaches through a single register offset: the line format register, whose fields set the character length, stop bits, parity and break condition of a serial link, and the bank register, which chooses which page of registers the host currently sees. Every host write at the offset loads the bank register. Whether the same write also loads the line format register depends on the top bits of the written byte. This lets software switch to a high register page without corrupting the serial format.

A read at the shared offset returns the bank register. The line format value can still be read: a shadow read port shows it while bank 3 is selected. The block also presents the decoded bank number and the unpacked line format fields as registered outputs. Surrounding register pages and the serialiser that consumes the format fields sit outside this block.

Top module: `line_bank_regs`

## Requirements
- R1: After a synchronous reset both registers are zero, so shared_rd, shadow_rd and bank_num are 0 and the format outputs show char_bits = 5 with all flags low.
- R2: A write strobe with wr_data bit 7 equal to 0 loads wr_data into both registers; the new values appear on the outputs after the clock edge that samples the strobe.
- R3: A write strobe whose bits 7:6 are 10 (a bank-1 code) loads wr_data into both registers.
- R4: A write strobe whose bits 7:6 are 11 loads only the bank register; the line format value keeps its previous contents.
- R5: shared_rd always equals the bank register contents, i.e. the last byte written at the offset.
- R6: bank_num is 0 when the bank register bit 7 is 0, 1 when bits 7:6 are 10, and 2 plus bits 3:2 when bits 7:6 are 11 (banks 2 to 5).
- R7: shadow_rd equals the full line format byte when bank_num is 3 and is 0 otherwise.
- R8: The format outputs decode the line format byte: char_bits = 5 + bits 1:0, two_stop = bit 2, par_en = bit 3, par_even = bit 4, par_stick = bit 5, brk = bit 6.
- R9: In a cycle without a write strobe, wr_data is ignored and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host write strobe for the shared offset |
| wr_data | input | 8 | Host write byte |
| shared_rd | output | 8 | Read data at the shared offset (bank register) |
| shadow_rd | output | 8 | Line format byte while bank 3 is selected, else 0 |
| bank_num | output | 3 | Decoded current bank number |
| char_bits | output | 4 | Character length in bits, 5 to 8 |
| two_stop | output | 1 | Extra stop bit select |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| par_stick | output | 1 | Stick parity select |
| brk | output | 1 | Force break on the line |

## Verification
The bench writes every one of the 256 byte values at the shared offset, once in ascending order and once in a scrambled order, so each value lands on a line format register that holds a different previous value; this separates writes that must reach both registers from writes that must leave the format untouched, since a wrong routing shows as a stale or overwritten format. The ascending pass hits every bank code, including the bank 3 codes that open the shadow port, and the scrambled pass shows that the shadow carries the retained format rather than the byte just written. Idle cycles with a changing data bus and no strobe separate strobe-qualified loading from loading on every edge.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  // Positions inside the written byte that steer routing and bank decode.
  localparam int SEL_BIT      = 7;   // bank-select-enable
  localparam int SUB_BIT      = 6;   // splits bank-1 codes from high banks
  localparam int HI_BANK_LSB  = 2;   // two-bit index of the high bank
  localparam int HI_BANK_BASE = 2;   // first high bank number

  // Positions of the line format fields.
  localparam int LEN_LSB   = 0;
  localparam int STOP_BIT  = 2;
  localparam int PEN_BIT   = 3;
  localparam int EVEN_BIT  = 4;
  localparam int STICK_BIT = 5;
  localparam int BRK_BIT   = 6;
  localparam int MIN_CHAR  = 5;

  typedef struct packed {
    logic [3:0] char_bits;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       brk;
  } line_fmt_t;

endpackage

// File: rtl/lbr_route.sv
module lbr_route #(
  parameter int DATA_W = 8
) (
  input  logic              wstb,
  input  logic [DATA_W-1:0] wdat,
  output logic              bsr_we,
  output logic              lcr_we
);
  import lbr_pkg::*;

  logic sel_en;
  logic bank1_code;

  always_comb begin
    sel_en     = wdat[SEL_BIT];
    bank1_code = wdat[SEL_BIT] & ~wdat[SUB_BIT];
    bsr_we     = wstb;
    // Format is protected only for high-bank selections.
    lcr_we     = wstb & (~sel_en | bank1_code);
  end

endmodule

// File: rtl/lbr_bank_dec.sv
module lbr_bank_dec #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input  logic [DATA_W-1:0] code,
  output logic [BANK_W-1:0] bank
);
  import lbr_pkg::*;

  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);
  localparam logic [BANK_W-1:0] BANK_HI0 = BANK_W'(HI_BANK_BASE);

  always_comb begin
    if (!code[SEL_BIT]) begin
      bank = '0;
    end else if (!code[SUB_BIT]) begin
      bank = BANK_ONE;
    end else begin
      bank = BANK_HI0 + BANK_W'(code[HI_BANK_LSB +: 2]);
    end
  end

endmodule

// File: rtl/lbr_fmt_unpack.sv
module lbr_fmt_unpack #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]       lcr,
  output lbr_pkg::line_fmt_t      fmt
);
  import lbr_pkg::*;

  always_comb begin
    fmt.char_bits = 4'(MIN_CHAR) + {2'b00, lcr[LEN_LSB +: 2]};
    fmt.two_stop  = lcr[STOP_BIT];
    fmt.par_en    = lcr[PEN_BIT];
    fmt.par_even  = lcr[EVEN_BIT];
    fmt.par_stick = lcr[STICK_BIT];
    fmt.brk       = lcr[BRK_BIT];
  end

endmodule

// File: rtl/line_bank_regs.sv
module line_bank_regs #(
  parameter int DATA_W      = 8,
  parameter int BANK_W      = 3,
  parameter int SHADOW_BANK = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] shared_rd,
  output logic [DATA_W-1:0] shadow_rd,
  output logic [BANK_W-1:0] bank_num,
  output logic [3:0]        char_bits,
  output logic              two_stop,
  output logic              par_en,
  output logic              par_even,
  output logic              par_stick,
  output logic              brk
);
  import lbr_pkg::*;

  localparam logic [BANK_W-1:0] SHADOW_SEL = BANK_W'(SHADOW_BANK);

  logic [DATA_W-1:0] bsr_q, lcr_q;
  logic [DATA_W-1:0] bsr_nxt, lcr_nxt, shadow_nxt;
  logic [BANK_W-1:0] bank_nxt;
  logic              bsr_we, lcr_we;
  line_fmt_t         fmt_nxt, fmt_q;

  lbr_route #(.DATA_W(DATA_W)) u_route (
    .wstb   (wr_stb),
    .wdat   (wr_data),
    .bsr_we (bsr_we),
    .lcr_we (lcr_we)
  );

  always_comb begin
    bsr_nxt = bsr_we ? wr_data : bsr_q;
    lcr_nxt = lcr_we ? wr_data : lcr_q;
  end

  lbr_bank_dec #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
    .code (bsr_nxt),
    .bank (bank_nxt)
  );

  lbr_fmt_unpack #(.DATA_W(DATA_W)) u_fmt (
    .lcr (lcr_nxt),
    .fmt (fmt_nxt)
  );

  always_comb begin
    shadow_nxt = (bank_nxt == SHADOW_SEL) ? lcr_nxt : '0;
  end

  // All outputs come straight from flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      bsr_q     <= '0;
      lcr_q     <= '0;
      bank_num  <= '0;
      shadow_rd <= '0;
      fmt_q     <= '{char_bits: 4'(MIN_CHAR), default: '0};
    end else begin
      bsr_q     <= bsr_nxt;
      lcr_q     <= lcr_nxt;
      bank_num  <= bank_nxt;
      shadow_rd <= shadow_nxt;
      fmt_q     <= fmt_nxt;
    end
  end

  always_comb begin
    shared_rd = bsr_q;
    char_bits = fmt_q.char_bits;
    two_stop  = fmt_q.two_stop;
    par_en    = fmt_q.par_en;
    par_even  = fmt_q.par_even;
    par_stick = fmt_q.par_stick;
    brk       = fmt_q.brk;
  end

endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] shared_rd,
  input logic [DATA_W-1:0] shadow_rd,
  input logic [BANK_W-1:0] bank_num,
  input logic [DATA_W-1:0] lcr_q
);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (shared_rd == '0 && lcr_q == '0 && bank_num == '0));

  // R2
  a_r2_both_loaded: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_data[DATA_W-1]) |=>
      (shared_rd == $past(wr_data) && lcr_q == $past(wr_data)));

  // R3
  a_r3_bank1_loads: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_data[DATA_W-1 -: 2] == 2'b10) |=>
      (lcr_q == $past(wr_data) && bank_num == BANK_W'(1)));

  // R4
  a_r4_format_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_data[DATA_W-1 -: 2] == 2'b11) |=>
      ($stable(lcr_q) && shared_rd == $past(wr_data)));

  // R7
  a_r7_shadow_gated: assert property (@(posedge clk) disable iff (rst)
    (bank_num != BANK_W'(3)) |-> (shadow_rd == '0));

  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(shared_rd) && $stable(lcr_q) && $stable(bank_num)));

endmodule

bind line_bank_regs lbr_checker #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_lbr_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .wr_data   (wr_data),
  .shared_rd (shared_rd),
  .shadow_rd (shadow_rd),
  .bank_num  (bank_num),
  .lcr_q     (lcr_q)
);

// File: tb/test_line_bank_regs.sv
`timescale 1ns/1ps
module test_line_bank_regs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] shared_rd, shadow_rd;
  logic [2:0] bank_num;
  logic [3:0] char_bits;
  logic       two_stop, par_en, par_even, par_stick, brk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] m_bsr = 8'h00;
  logic [7:0] m_lcr = 8'h00;

  always #4 clk = ~clk;

  line_bank_regs i_line_bank_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .shared_rd(shared_rd), .shadow_rd(shadow_rd), .bank_num(bank_num),
    .char_bits(char_bits), .two_stop(two_stop), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .brk(brk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_bank(input logic [7:0] b);
    if (!b[7]) return 3'd0;
    if (!b[6]) return 3'd1;
    return 3'd2 + {1'b0, b[3:2]};
  endfunction

  function automatic logic [8:0] exp_fmt(input logic [7:0] l);
    return {4'd5 + {2'b00, l[1:0]}, l[2], l[3], l[4], l[5], l[6]};
  endfunction

  task automatic check_all(input string tag);
    logic [2:0] b;
    b = exp_bank(m_bsr);
    check({tag, " R5 shared_rd"}, shared_rd, m_bsr);
    check({tag, " R6 bank_num"}, bank_num, b);
    check({tag, " R7 shadow_rd"}, shadow_rd, (b == 3'd3) ? m_lcr : 8'h00);
    check({tag, " R8 fields"},
          {char_bits, two_stop, par_en, par_even, par_stick, brk},
          exp_fmt(m_lcr));
  endtask

  task automatic do_write(input logic [7:0] v);
    string tag;
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_stb  = 1'b0;
    m_bsr = v;
    if (!v[7]) begin
      m_lcr = v; tag = "R2";
    end else if (!v[6]) begin
      m_lcr = v; tag = "R3";
    end else begin
      tag = "R4";
    end
    check_all(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    check_all("R1");
    check("R1 char_bits", char_bits, 5);

    // Ascending sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      do_write(8'(v));
    end

    // Scrambled sweep: each value lands on a different prior format
    for (int v = 0; v < 256; v++) begin
      do_write(8'((v * 37 + 11) % 256) ^ 8'h5A);
    end

    // R9: idle cycles with a moving data bus
    for (int k = 0; k < 16; k++) begin
      do_write(8'(k * 17 + 3));
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        wr_data = ~wr_data;
        @(negedge clk);
        check_all("R9");
      end
    end

    // R1 again: reset from a loaded state
    do_write(8'h7F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_bsr = 8'h00;
    m_lcr = 8'h00;
    check_all("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule